// File: doc/BRIEF.md
# Dual Countdown Timer

This block holds two identical 24-bit down-counting timers behind a small synchronous register bus. Each timer has a bank of four 32-bit registers: a reload value, a read-only view of the live count, a control word and an interrupt acknowledge. The control word turns the timer on, chooses between one-shot and auto-reload operation, and selects how often the counter steps: every clock, every 16 clocks or every 256 clocks. An up-counting time base is obtained by inverting the live count.

Software stops a timer by writing zero to its control word. It starts a count by writing the reload value and then the control word. When a running count steps from one to zero, that timer's interrupt output goes high and stays high until software writes its acknowledge register. In auto-reload mode the count takes the reload value again on the next step. In one-shot mode it stays at zero. Reads are combinational from the address, and writes take effect on the rising clock edge while the write enable is high.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset every register of both banks reads zero and both interrupt outputs are low.
- R2: A write to the reload register (bank offset 0x0) stores the low 24 bits of the write data, loads the same value into the live count on that edge, and restarts the step divider. A control write (offset 0x8) also restarts the divider.
- R3: Timer 0's bank starts at byte address 0x00 and timer 1's at 0x20. Within a bank the offsets are 0x0 reload, 0x4 live count, 0x8 control and 0xC acknowledge. Addresses 0x10 to 0x1F and 0x30 to 0x3F read zero, and writes to them change nothing.
- R4: In the control word, bit 7 is enable, bit 6 is auto-reload and bits 3:2 are the divider code. All other bits read back as zero, and the acknowledge register reads zero.
- R5: With divider code 0 and enable set, the count drops by one on every clock edge that follows the control write.
- R6: Divider code 1 steps the count once every 16 clocks and codes 2 and 3 step it once every 256 clocks. The first step falls on the 16th (or 256th) edge after the last reload or control write.
- R7: A step that takes the count from 1 to 0 sets the timer's interrupt output, which stays high at its level until it is acknowledged.
- R8: In one-shot mode (bit 6 clear) a count of zero stays at zero on later steps.
- R9: In auto-reload mode (bit 6 set) the step after the count reaches zero loads the reload value.
- R10: A write of any data to the acknowledge register clears the interrupt. If the same edge also steps the count from 1 to 0, the interrupt is set instead.
- R11: Writes to the live-count register have no effect on any register.
- R12: While enable is clear, the live count holds its value.
- R13: The two timers are independent. Traffic to one bank and the other's interrupt do not change a timer's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, sampled at the rising edge |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 2 | Level interrupt, one bit per timer |

## Verification
The hardest case to reach from the ports is an acknowledge write that lands on the same edge as the step from 1 to 0, where the set has to win. The stimulus reaches it by running an auto-reload timer with divider 1 and a reload value of 3. Since every cycle of the count is known, the bench first acknowledges on the edge where the count reloads and then issues a second acknowledge on the edge where the count leaves 1. The slow divider phases are covered by waiting exactly 15 or 255 cycles after the control write and checking that the count has not moved, then checking that it moves one edge later.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int CNT_W     = 24;
  localparam int DATA_W    = 32;
  localparam int BANK_LSB  = 5;   // 0x20 bank stride
  localparam int EN_BIT    = 7;
  localparam int RELOAD_BIT = 6;
  localparam int DIV_LSB   = 2;
  localparam int DIV16_LOG  = 4;
  localparam int DIV256_LOG = 8;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_LIVE   = 2'd1,
    REG_CTRL   = 2'd2,
    REG_ACK    = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       en;
    logic       reload;
    logic [1:0] div;
  } ctrl_t;
endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler
  import dtmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [1:0] div_i,
  output logic       tick_o
);
  localparam int PRE_W = DIV256_LOG;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pre_q <= '0;
    else if (restart_i || !run_i) pre_q <= '0;
    else                          pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    unique case (div_i)
      2'd0:    tick_o = run_i;
      2'd1:    tick_o = run_i && (&pre_q[DIV16_LOG-1:0]);
      default: tick_o = run_i && (&pre_q[DIV256_LOG-1:0]); // codes 2 and 3
    endcase
  end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_we_i,
  input  logic              ctrl_we_i,
  input  logic              ack_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CNT_W-1:0]  count_o,
  output ctrl_t             ctrl_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] reload_q, count_q;
  ctrl_t            ctrl_q;
  logic             irq_q;
  logic             tick;
  logic             hit_zero;

  dtmr_prescaler u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl_q.en),
    .restart_i(reload_we_i || ctrl_we_i),
    .div_i    (ctrl_q.div),
    .tick_o   (tick)
  );

  assign hit_zero = tick && !reload_we_i && (count_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we_i) begin
      ctrl_q.en     <= wdata_i[EN_BIT];
      ctrl_q.reload <= wdata_i[RELOAD_BIT];
      ctrl_q.div    <= wdata_i[DIV_LSB+1:DIV_LSB];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      count_q  <= '0;
    end else if (reload_we_i) begin
      reload_q <= wdata_i[CNT_W-1:0];
      count_q  <= wdata_i[CNT_W-1:0];
    end else if (tick) begin
      if (count_q == '0) begin
        if (ctrl_q.reload) count_q <= reload_q;
      end else begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  // set wins over a same-edge acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_q <= 1'b0;
    else if (hit_zero) irq_q <= 1'b1;
    else if (ack_we_i) irq_q <= 1'b0;
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
  assign ctrl_o   = ctrl_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/dtmr_decode.sv
module dtmr_decode
  import dtmr_pkg::*;
#(
  parameter int NUM_TMR = 2,
  parameter int ADDR_W  = 6
) (
  input  logic              [ADDR_W-1:0] addr_i,
  input  logic                           we_i,
  output logic                           hit_o,
  output logic [ADDR_W-BANK_LSB-1:0]     bank_o,
  output reg_sel_e                       sel_o,
  output logic              [NUM_TMR-1:0] reload_we_o,
  output logic              [NUM_TMR-1:0] ctrl_we_o,
  output logic              [NUM_TMR-1:0] ack_we_o
);
  assign bank_o = addr_i[ADDR_W-1:BANK_LSB];
  assign sel_o  = reg_sel_e'(addr_i[3:2]);
  assign hit_o  = !addr_i[BANK_LSB-1] && (int'(bank_o) < NUM_TMR);

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_strobe
    logic mine;
    assign mine           = we_i && hit_o && (int'(bank_o) == g);
    assign reload_we_o[g] = mine && (sel_o == REG_RELOAD);
    assign ctrl_we_o[g]   = mine && (sel_o == REG_CTRL);
    assign ack_we_o[g]    = mine && (sel_o == REG_ACK);
  end
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
  import dtmr_pkg::*;
#(
  parameter int NUM_TMR = 2,
  parameter int ADDR_W  = 6   // must cover NUM_TMR banks of 0x20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               we_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_TMR-1:0] irq_o
);
  localparam int BANK_W = ADDR_W - BANK_LSB;

  logic                          hit;
  logic [BANK_W-1:0]             bank;
  reg_sel_e                      sel;
  logic [NUM_TMR-1:0]            reload_we_w, ctrl_we_w, ack_we_w;
  logic [NUM_TMR-1:0][CNT_W-1:0] reload_w, cnt_w;
  ctrl_t [NUM_TMR-1:0]           ctrl_w;
  logic [NUM_TMR-1:0]            en_w, mode_w;

  dtmr_decode #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W)) u_dec (
    .addr_i     (addr_i),
    .we_i       (we_i),
    .hit_o      (hit),
    .bank_o     (bank),
    .sel_o      (sel),
    .reload_we_o(reload_we_w),
    .ctrl_we_o  (ctrl_we_w),
    .ack_we_o   (ack_we_w)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    dtmr_channel u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .reload_we_i(reload_we_w[g]),
      .ctrl_we_i  (ctrl_we_w[g]),
      .ack_we_i   (ack_we_w[g]),
      .wdata_i    (wdata_i),
      .reload_o   (reload_w[g]),
      .count_o    (cnt_w[g]),
      .ctrl_o     (ctrl_w[g]),
      .irq_o      (irq_o[g])
    );
    assign en_w[g]   = ctrl_w[g].en;
    assign mode_w[g] = ctrl_w[g].reload;
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      unique case (sel)
        REG_RELOAD: rdata_o = DATA_W'(reload_w[bank]);
        REG_LIVE:   rdata_o = DATA_W'(cnt_w[bank]);
        REG_CTRL: begin
          rdata_o[EN_BIT]              = ctrl_w[bank].en;
          rdata_o[RELOAD_BIT]          = ctrl_w[bank].reload;
          rdata_o[DIV_LSB+1:DIV_LSB]   = ctrl_w[bank].div;
        end
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
  import dtmr_pkg::*;
#(
  parameter int NUM_TMR = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [DATA_W-1:0]             wdata_i,
  input logic [NUM_TMR-1:0]            irq_i,
  input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_i,
  input logic [NUM_TMR-1:0]            en_i,
  input logic [NUM_TMR-1:0]            mode_i,
  input logic [NUM_TMR-1:0]            reload_we_i,
  input logic [NUM_TMR-1:0]            ack_we_i
);
  for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
    p_load_sets_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reload_we_i[g] |=> cnt_i[g] == $past(wdata_i[CNT_W-1:0]));

    p_irq_rise_at_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_i[g]) |-> cnt_i[g] == '0);

    p_irq_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_i[g] && !ack_we_i[g]) |=> irq_i[g]);

    p_oneshot_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[g] && !mode_i[g] && cnt_i[g] == '0 && !reload_we_i[g]) |=> cnt_i[g] == '0);

    p_ack_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_we_i[g] && cnt_i[g] != CNT_W'(1)) |=> !irq_i[g]);

    p_hold_when_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i[g] && !reload_we_i[g]) |=> $stable(cnt_i[g]));
  end
endmodule

bind dual_countdown_timer dtmr_checker #(.NUM_TMR(NUM_TMR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wdata_i    (wdata_i),
  .irq_i      (irq_o),
  .cnt_i      (cnt_w),
  .en_i       (en_w),
  .mode_i     (mode_w),
  .reload_we_i(reload_we_w),
  .ack_we_i   (ack_we_w)
);

// File: tb/dual_countdown_timer_bench.sv
module dual_countdown_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_fail = 0;

  dual_countdown_timer u_dual_countdown_timer (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .wdata_i(wdata),
    .we_i   (we),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the following posedge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 64; a += 4) begin
      rd(6'(a), d);
      check("R1 reset read", d, 32'h0);
    end
    check("R1 reset irq", {30'h0, irq}, 32'h0);
  endtask

  task automatic t_oneshot;
    logic [31:0] d;
    wr(6'h00, 32'd5);
    wr(6'h08, 32'h80);
    rd(6'h04, d); check("R5 count after start", d, 32'd5);
    wait_cyc(4);
    rd(6'h04, d); check("R5 count after 4", d, 32'd1);
    check("R7 no irq yet", {31'h0, irq[0]}, 32'h0);
    wait_cyc(1);
    rd(6'h04, d); check("R5 count at zero", d, 32'd0);
    check("R7 irq set", {31'h0, irq[0]}, 32'h1);
    wait_cyc(3);
    rd(6'h04, d); check("R8 oneshot holds zero", d, 32'd0);
    check("R7 irq level held", {31'h0, irq[0]}, 32'h1);
    wr(6'h0C, 32'hDEAD_BEEF);
    check("R10 ack clears", {31'h0, irq[0]}, 32'h0);
    wr(6'h08, 32'h0);
  endtask

  task automatic t_periodic;
    logic [31:0] d;
    wr(6'h00, 32'd3);
    wr(6'h08, 32'hC0);
    wait_cyc(3);
    rd(6'h04, d); check("R9 count zero", d, 32'd0);
    check("R7 periodic irq", {31'h0, irq[0]}, 32'h1);
    wait_cyc(1);
    rd(6'h04, d); check("R9 reload", d, 32'd3);
    wait_cyc(1);
    rd(6'h04, d); check("R9 count after reload", d, 32'd2);
    wr(6'h0C, 32'h0);
    check("R10 ack in periodic", {31'h0, irq[0]}, 32'h0);
    rd(6'h04, d); check("R9 count 1", d, 32'd1);
    wait_cyc(1);
    check("R7 irq again", {31'h0, irq[0]}, 32'h1);
    wr(6'h0C, 32'h0);   // count 0 -> 3, irq cleared
    check("R10 ack on reload edge", {31'h0, irq[0]}, 32'h0);
    wait_cyc(2);        // count 1
    rd(6'h04, d); check("R9 count 1 again", d, 32'd1);
    wr(6'h0C, 32'h0);   // same edge as 1 -> 0
    check("R10 set wins over ack", {31'h0, irq[0]}, 32'h1);
    wr(6'h08, 32'h0);
    wr(6'h0C, 32'h0);
    check("R10 final ack", {31'h0, irq[0]}, 32'h0);
  endtask

  task automatic t_div16;
    logic [31:0] d;
    wr(6'h00, 32'd2);
    wr(6'h08, 32'h84);
    wait_cyc(15);
    rd(6'h04, d); check("R6 div16 not yet", d, 32'd2);
    wait_cyc(1);
    rd(6'h04, d); check("R6 div16 first step", d, 32'd1);
    wait_cyc(15);
    rd(6'h04, d); check("R6 div16 hold", d, 32'd1);
    wait_cyc(1);
    rd(6'h04, d); check("R6 div16 second step", d, 32'd0);
    check("R7 div16 irq", {31'h0, irq[0]}, 32'h1);
    wr(6'h08, 32'h0);
    wr(6'h0C, 32'h0);
  endtask

  task automatic t_div256(input logic [31:0] ctrl, input string tag);
    logic [31:0] d;
    wr(6'h00, 32'd1);
    wr(6'h08, ctrl);
    rd(6'h08, d); check({"R4 ctrl readback ", tag}, d, ctrl);
    wait_cyc(255);
    rd(6'h04, d); check({"R6 div256 not yet ", tag}, d, 32'd1);
    wait_cyc(1);
    rd(6'h04, d); check({"R6 div256 step ", tag}, d, 32'd0);
    wr(6'h08, 32'h0);
    wr(6'h0C, 32'h0);
  endtask

  task automatic t_stop_and_ignore;
    logic [31:0] d;
    wr(6'h00, 32'd10);
    wr(6'h08, 32'h80);
    wait_cyc(3);
    rd(6'h04, d); check("R5 running", d, 32'd7);
    wr(6'h08, 32'h0);   // last step lands on this edge
    wait_cyc(5);
    rd(6'h04, d); check("R12 disabled holds", d, 32'd6);
    wr(6'h04, 32'h123);
    rd(6'h04, d); check("R11 live write ignored", d, 32'd6);
    rd(6'h00, d); check("R11 reload untouched", d, 32'd10);
    rd(6'h08, d); check("R11 ctrl untouched", d, 32'h0);
    wr(6'h08, 32'hFFFF_FF3F);
    rd(6'h08, d); check("R4 unused ctrl bits zero", d, 32'h0000_000C);
    rd(6'h0C, d); check("R4 ack reads zero", d, 32'h0);
    wr(6'h08, 32'h0);
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, d); check("R2 reload 24 bits", d, 32'h00FF_FFFF);
    rd(6'h04, d); check("R2 count follows reload", d, 32'h00FF_FFFF);
  endtask

  task automatic t_banks;
    logic [31:0] d;
    wr(6'h20, 32'd4);
    wr(6'h28, 32'h80);
    wait_cyc(4);
    check("R13 timer1 irq", {30'h0, irq}, 32'h2);
    rd(6'h24, d); check("R3 timer1 count", d, 32'd0);
    rd(6'h04, d); check("R13 timer0 untouched", d, 32'h00FF_FFFF);
    wr(6'h2C, 32'h0);
    check("R13 timer1 ack", {30'h0, irq}, 32'h0);
    wr(6'h10, 32'h55);
    wr(6'h34, 32'h66);
    rd(6'h10, d); check("R3 hole reads zero", d, 32'h0);
    rd(6'h30, d); check("R3 upper hole reads zero", d, 32'h0);
    rd(6'h00, d); check("R3 hole write no effect t0", d, 32'h00FF_FFFF);
    rd(6'h20, d); check("R3 hole write no effect t1", d, 32'd4);
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(1);
    t_oneshot();
    t_periodic();
    t_div16();
    t_div256(32'h88, "code2");
    t_div256(32'h8C, "code3");
    t_stop_and_ignore();
    t_banks();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule